// File: doc/BRIEF.md
# Standby and Sleep Power-State Controller

This block decides where a processor goes when it executes its sleep instruction, and how it comes back. The CPU sets three configuration fields: a standby-enable bit, a 3-bit settling-time code and a bus-hold bit. When the CPU raises its sleep request, the block enters one of two states. With standby disabled it enters a light sleep, in which only the CPU clock is gated. With standby enabled it enters a deep standby, which only an external wake interrupt can end.

Leaving standby is not immediate. After the wake interrupt the oscillator needs time to settle, so the block counts a programmed number of clock states before it re-enables the CPU clock. During standby the bus-hold bit decides how the external bus looks. The address and strobe pins can float, or the address can be frozen at its last value while the active-low strobes are driven inactive (high). A mode output reports the current state. A flag marks the reserved settling code.

All settling lengths are divided by `2**SCALE_LOG2`. A shift of 0 gives the full hardware lengths.

Top module: `stby_pwr_ctrl`

## Requirements
- R1: In normal mode (mode code 00), a sampled `sleep_req` moves the block on the next clock to sleep (01) when `stby_en` is 0, or to standby (10) when `stby_en` is 1.
- R2: The configuration fields (`stby_en`, `settle_sel`, `hold_bus`) change only on a clock with `cfg_we` high. In particular, `stby_en` is still 1 after a return from standby.
- R3: Settling codes 0 to 5 give `(8192 << code) >> SCALE_LOG2` clock cycles in settling mode (11). Code 6 gives `1024 >> SCALE_LOG2` cycles.
- R4: Code 7 is reserved. While it is selected, `settle_illegal` is 1, and the settling time is `262144 >> SCALE_LOG2` cycles. For every other code, `settle_illegal` is 0.
- R5: In standby, a sampled `wake_irq` moves the block to settling on the next clock. `cpu_clk_en` is 1 exactly when the mode is normal, so it rises on the clock after the last settling cycle.
- R6: In sleep, a sampled `any_irq` returns the block to normal on the next clock, with no settling. In standby, `any_irq` has no effect.
- R7: In standby with `hold_bus` 0, `addr_oe` and `ctrl_oe` are both 0 (high-impedance).
- R8: In standby with `hold_bus` 1, both enables are 1. `addr_out` equals the address driven on the last cycle before standby, and `ctrl_out` is all ones.
- R9: Outside standby, `addr_out` follows `addr_in`, `ctrl_out` follows `ctrl_in`, and both enables are 1.
- R10: After reset, the mode is normal, all configuration fields are 0 and `cpu_clk_en` is 1.
- R11: `sleep_req` has no effect outside normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration fields |
| cfg_stby_en | input | 1 | Standby-enable value to write |
| cfg_settle_sel | input | 3 | Settling code to write |
| cfg_hold_bus | input | 1 | Bus-hold value to write |
| sleep_req | input | 1 | CPU sleep instruction strobe |
| wake_irq | input | 1 | External interrupt that ends standby |
| any_irq | input | 1 | Any enabled interrupt; ends sleep |
| addr_in | input | ADDR_W | Address from the CPU |
| ctrl_in | input | CTRL_W | Active-low bus strobes from the CPU |
| stby_en | output | 1 | Current standby-enable bit |
| settle_sel | output | 3 | Current settling code |
| hold_bus | output | 1 | Current bus-hold bit |
| settle_illegal | output | 1 | Reserved settling code selected |
| mode | output | 2 | 00 normal, 01 sleep, 10 standby, 11 settling |
| cpu_clk_en | output | 1 | CPU clock enable |
| addr_out | output | ADDR_W | Address pin value |
| addr_oe | output | 1 | Address pin drive enable |
| ctrl_out | output | CTRL_W | Strobe pin values |
| ctrl_oe | output | 1 | Strobe pin drive enable |

## Verification
The bench builds the block with `SCALE_LOG2 = 7`, `ADDR_W = 16` and `CTRL_W = 4`. This shrinks the settling runs to between 8 and 2048 cycles. As a result, every one of the eight codes can be run to completion, and its exact length counted, within one short run. That includes the reordered short code and the reserved longest code. The changing address pattern makes the frozen standby address distinguishable from live traffic.

// File: rtl/stby_pwr_pkg.sv
package stby_pwr_pkg;

    localparam int SETTLE_W = 19;

    typedef enum logic [1:0] {
        PM_NORMAL = 2'b00,
        PM_SLEEP  = 2'b01,
        PM_STBY   = 2'b10,
        PM_SETTLE = 2'b11
    } pm_mode_e;

    typedef struct packed {
        logic       stby_en;
        logic [2:0] settle_sel;
        logic       hold_bus;
    } pm_cfg_t;

    localparam logic [2:0] SEL_RESERVED = 3'd7;

    // Settling length in clock cycles for a code, already scaled down.
    function automatic logic [SETTLE_W-1:0] settle_cycles(input logic [2:0] sel,
                                                          input int unsigned shift);
        logic [SETTLE_W-1:0] base;
        case (sel)
            3'd6:    base = SETTLE_W'(1024);
            3'd7:    base = SETTLE_W'(262144);
            default: base = SETTLE_W'(8192) << sel;
        endcase
        return base >> shift;
    endfunction

endpackage

// File: rtl/stby_cfg_regs.sv
module stby_cfg_regs
    import stby_pwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    we,
    input  pm_cfg_t wdata,
    output pm_cfg_t cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            cfg <= wdata;
        end
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pwr_pkg::*;
#(
    parameter int unsigned SCALE_LOG2 = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic       wake_irq,
    input  logic       any_irq,
    input  logic       stby_en,
    input  logic [2:0] settle_sel,
    output pm_mode_e   mode,
    output logic       settle_illegal
);

    logic [SETTLE_W-1:0] cnt;
    logic [SETTLE_W-1:0] limit;

    assign limit          = settle_cycles(settle_sel, SCALE_LOG2);
    assign settle_illegal = (settle_sel == SEL_RESERVED);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= PM_NORMAL;
            cnt  <= '0;
        end else begin
            case (mode)
                PM_NORMAL: if (sleep_req) mode <= stby_en ? PM_STBY : PM_SLEEP;
                PM_SLEEP:  if (any_irq)   mode <= PM_NORMAL;
                PM_STBY: begin
                    if (wake_irq) begin
                        mode <= PM_SETTLE;
                        cnt  <= '0;
                    end
                end
                PM_SETTLE: begin
                    if (cnt == limit - SETTLE_W'(1)) mode <= PM_NORMAL;
                    else                             cnt  <= cnt + SETTLE_W'(1);
                end
                default: mode <= PM_NORMAL;
            endcase
        end
    end

    assert_sleep_target_R1: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_NORMAL && sleep_req) |=> (mode == ($past(stby_en) ? PM_STBY : PM_SLEEP)));

    assert_settle_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SETTLE) |-> (cnt < limit));

    assert_wake_settle_R5: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STBY && wake_irq) |=> (mode == PM_SETTLE));

    assert_sleep_exit_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_SLEEP && any_irq) |=> (mode == PM_NORMAL));

    assert_stby_ignores_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_STBY && !wake_irq) |=> (mode == PM_STBY));

endmodule

// File: rtl/stby_bus_ctl.sv
module stby_bus_ctl
    import stby_pwr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  pm_mode_e          mode,
    input  logic              hold_bus,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              ctrl_oe
);

    logic [ADDR_W-1:0] addr_last;
    logic              in_stby;

    assign in_stby = (mode == PM_STBY);

    always_ff @(posedge clk) begin
        if (rst)           addr_last <= '0;
        else if (!in_stby) addr_last <= addr_in;
    end

    always_comb begin
        addr_out = addr_in;
        ctrl_out = ctrl_in;
        addr_oe  = 1'b1;
        ctrl_oe  = 1'b1;
        if (in_stby) begin
            addr_out = addr_last;
            ctrl_out = '1;
            addr_oe  = hold_bus;
            ctrl_oe  = hold_bus;
        end
    end

    assert_float_bus_R7: assert property (@(posedge clk) disable iff (rst)
        (in_stby && !hold_bus) |-> (!addr_oe && !ctrl_oe));

    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (rst)
        (in_stby && $past(in_stby) && hold_bus) |-> ($stable(addr_out) && addr_oe && (&ctrl_out)));

    assert_pass_bus_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_stby) |-> (addr_out == addr_in && ctrl_out == ctrl_in && addr_oe && ctrl_oe));

endmodule

// File: rtl/stby_pwr_ctrl.sv
module stby_pwr_ctrl
    import stby_pwr_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          CTRL_W     = 4,
    parameter int unsigned SCALE_LOG2 = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_stby_en,
    input  logic [2:0]        cfg_settle_sel,
    input  logic              cfg_hold_bus,
    input  logic              sleep_req,
    input  logic              wake_irq,
    input  logic              any_irq,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CTRL_W-1:0] ctrl_in,
    output logic              stby_en,
    output logic [2:0]        settle_sel,
    output logic              hold_bus,
    output logic              settle_illegal,
    output logic [1:0]        mode,
    output logic              cpu_clk_en,
    output logic [ADDR_W-1:0] addr_out,
    output logic              addr_oe,
    output logic [CTRL_W-1:0] ctrl_out,
    output logic              ctrl_oe
);

    pm_cfg_t  wr_cfg;
    pm_cfg_t  cur_cfg;
    pm_mode_e cur_mode;

    assign wr_cfg = '{stby_en: cfg_stby_en, settle_sel: cfg_settle_sel, hold_bus: cfg_hold_bus};

    stby_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (wr_cfg),
        .cfg   (cur_cfg)
    );

    stby_fsm #(.SCALE_LOG2(SCALE_LOG2)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .sleep_req      (sleep_req),
        .wake_irq       (wake_irq),
        .any_irq        (any_irq),
        .stby_en        (cur_cfg.stby_en),
        .settle_sel     (cur_cfg.settle_sel),
        .mode           (cur_mode),
        .settle_illegal (settle_illegal)
    );

    stby_bus_ctl #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_bus (
        .clk      (clk),
        .rst      (rst),
        .mode     (cur_mode),
        .hold_bus (cur_cfg.hold_bus),
        .addr_in  (addr_in),
        .ctrl_in  (ctrl_in),
        .addr_out (addr_out),
        .addr_oe  (addr_oe),
        .ctrl_out (ctrl_out),
        .ctrl_oe  (ctrl_oe)
    );

    assign stby_en    = cur_cfg.stby_en;
    assign settle_sel = cur_cfg.settle_sel;
    assign hold_bus   = cur_cfg.hold_bus;
    assign mode       = cur_mode;
    assign cpu_clk_en = (cur_mode == PM_NORMAL);

    assert_keep_stby_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == PM_SETTLE && !cfg_we) |=> stby_en);

    assert_no_spurious_sleep_R11: assert property (@(posedge clk) disable iff (rst)
        (cur_mode == PM_SETTLE && sleep_req) |=> (cur_mode inside {PM_SETTLE, PM_NORMAL}));

endmodule

// File: tb/stby_pwr_ctrl_tb.sv
module stby_pwr_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int SH = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 0, cfg_stby_en = 0, cfg_hold_bus = 0;
    logic [2:0]    cfg_settle_sel = 0;
    logic          sleep_req = 0, wake_irq = 0, any_irq = 0;
    logic [AW-1:0] addr_in = 16'h1234;
    logic [CW-1:0] ctrl_in = 4'b1010;
    logic          stby_en, hold_bus, settle_illegal, cpu_clk_en, addr_oe, ctrl_oe;
    logic [2:0]    settle_sel;
    logic [1:0]    mode;
    logic [AW-1:0] addr_out;
    logic [CW-1:0] ctrl_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model state
    int        m_mode = 0;
    int        m_rem  = 0;
    bit        m_stby = 0, m_hold = 0;
    int        m_sel  = 0;
    logic [AW-1:0] m_last = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_pwr_ctrl #(.ADDR_W(AW), .CTRL_W(CW), .SCALE_LOG2(SH)) dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stby_en(cfg_stby_en),
        .cfg_settle_sel(cfg_settle_sel), .cfg_hold_bus(cfg_hold_bus),
        .sleep_req(sleep_req), .wake_irq(wake_irq), .any_irq(any_irq),
        .addr_in(addr_in), .ctrl_in(ctrl_in), .stby_en(stby_en),
        .settle_sel(settle_sel), .hold_bus(hold_bus), .settle_illegal(settle_illegal),
        .mode(mode), .cpu_clk_en(cpu_clk_en), .addr_out(addr_out), .addr_oe(addr_oe),
        .ctrl_out(ctrl_out), .ctrl_oe(ctrl_oe)
    );

    function automatic int exp_len(input int sel);
        int base;
        if (sel == 6)      base = 1024;
        else if (sel == 7) base = 262144;
        else               base = 8192 << sel;
        return base >> SH;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // model advance at the clock edge
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_mode = 0; m_stby = 0; m_hold = 0; m_sel = 0; m_last = '0; m_rem = 0;
        end else begin
            if (m_mode != 2) m_last = addr_in;
            case (m_mode)
                0: if (sleep_req) m_mode = m_stby ? 2 : 1;
                1: if (any_irq) m_mode = 0;
                2: if (wake_irq) begin m_mode = 3; m_rem = exp_len(m_sel); end
                default: begin m_rem--; if (m_rem == 0) m_mode = 0; end
            endcase
            if (cfg_we) begin m_stby = cfg_stby_en; m_sel = cfg_settle_sel; m_hold = cfg_hold_bus; end
        end
    end

    // per-cycle comparison away from the edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1 mode", mode, m_mode);
            chk("R5 cpu_clk_en", cpu_clk_en, m_mode == 0);
            chk("R2 cfg", {stby_en, settle_sel, hold_bus}, {m_stby, 3'(m_sel), m_hold});
            chk("R4 illegal", settle_illegal, m_sel == 7);
            if (m_mode == 2) begin
                chk("R7 addr_oe", addr_oe, m_hold);
                chk("R7 ctrl_oe", ctrl_oe, m_hold);
                if (m_hold) begin
                    chk("R8 addr_out", addr_out, m_last);
                    chk("R8 ctrl_out", ctrl_out, {CW{1'b1}});
                end
            end else begin
                chk("R9 addr_out", addr_out, addr_in);
                chk("R9 ctrl_out", ctrl_out, ctrl_in);
                chk("R9 oe", {addr_oe, ctrl_oe}, 2'b11);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            addr_in = addr_in * 16'd37 + 16'd11;
            ctrl_in = ~ctrl_in;
        end
    endtask

    task automatic wr(input bit se, input int sel, input bit hb);
        cfg_we = 1; cfg_stby_en = se; cfg_settle_sel = 3'(sel); cfg_hold_bus = hb;
        cyc(1);
        cfg_we = 0;
    endtask

    task automatic pulse_sleep();
        sleep_req = 1; cyc(1); sleep_req = 0;
    endtask

    // standby round trip with the settling length counted at the ports
    task automatic stby_trip(input int sel, input bit hb);
        int n;
        wr(1, sel, hb);
        pulse_sleep();
        #1 chk("R1 standby entry", mode, 2'b10);
        any_irq = 1; sleep_req = 1; cyc(3); any_irq = 0; sleep_req = 0;
        #1 chk("R6 any_irq ignored in standby", mode, 2'b10);
        chk("R11 sleep_req ignored in standby", mode, 2'b10);
        wake_irq = 1; cyc(1); wake_irq = 0;
        #1 chk("R5 settle after wake", mode, 2'b11);
        n = 0;
        while (mode == 2'b11 && n < 300000) begin n++; cyc(1); #1; end
        chk(sel == 7 ? "R4 reserved length" : "R3 settle length", n, exp_len(sel));
        chk("R5 clock enable back", cpu_clk_en, 1);
        chk("R2 stby_en kept", stby_en, 1);
    endtask

    initial begin
        cyc(3);
        rst = 0;
        #1;
        chk("R10 mode", mode, 0);
        chk("R10 cfg", {stby_en, settle_sel, hold_bus}, 0);
        chk("R10 cpu_clk_en", cpu_clk_en, 1);
        cyc(2);
        pulse_sleep();
        #1 chk("R1 sleep entry", mode, 2'b01);
        chk("R5 clock gated in sleep", cpu_clk_en, 0);
        sleep_req = 1; cyc(2); sleep_req = 0;
        #1 chk("R11 sleep_req ignored in sleep", mode, 2'b01);
        any_irq = 1; cyc(1); any_irq = 0;
        #1 chk("R6 sleep exit", mode, 2'b00);
        for (int s = 0; s < 8; s++) stby_trip(s, s[0]);
        wr(0, 0, 0);
        pulse_sleep();
        #1 chk("R2 cleared stby_en gives sleep", mode, 2'b01);
        any_irq = 1; cyc(1); any_irq = 0;
        cyc(4);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule